// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steers a multi-cycle datapath from a small microprogram rather than from a hand-drawn state machine. A microaddress register selects one word of a built-in microcode store. A decoder expands that word's fields into the individual datapath strobes: PC load, memory read and write, instruction latch, register-file write, ALU function and operand selects. Every word also carries a two-bit sequencing field, which picks the next microaddress. The choices are the next word in order, a return to the fetch word, or a jump through one of two opcode-indexed dispatch tables.

The opcode input comes from the instruction register that sits outside this block. The sequencer reads it only in the two dispatch words and ignores it in every other word. The microprogram has ten words at fixed addresses:

| Address | Word |
|---|---|
| 0 | fetch |
| 1 | decode |
| 2 | memory address |
| 3 | load read |
| 4 | load write-back |
| 5 | store |
| 6 | register ALU operation |
| 7 | register write-back |
| 8 | branch compare |
| 9 | jump |

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low (asynchronous, active low), upc is 0 and the outputs show the fetch word.
- R2: Sequencing code 11 advances upc to upc+1 on the next clock edge.
- R3: Sequencing code 00 returns upc to 0 (fetch) on the next clock edge.
- R4: Sequencing code 01 dispatches through the first table, which sends opcode 6'h00 (register) to 6, 6'h02 (jump) to 9, 6'h04 (branch) to 8, and 6'h23 (load) or 6'h2B (store) to 2.
- R5: Sequencing code 10 dispatches through the second table, which sends load to 3 and store to 5, using the opcode present in that same cycle.
- R6: An opcode that has no entry in the active dispatch table sends upc to 0.
- R7: Word 0 asserts mem_rd, ir_ld and pc_wr, with addr_sel=0, pc_src=00, alu_fn=00, alu_a_sel=0 and alu_b_sel=01. Word 0 sequences with code 11.
- R8: Word 1 asserts no strobe, with alu_fn=00, alu_a_sel=0 and alu_b_sel=11. Word 1 sequences with code 01.
- R9: The memory words behave as follows. Word 2 gives alu_a_sel=1, alu_b_sel=10 and alu_fn=00, and uses code 10. Word 3 gives mem_rd with addr_sel=1 and uses code 11. Word 5 gives mem_wr with addr_sel=1 and uses code 00.
- R10: The register words behave as follows. Word 6 gives alu_fn=10, alu_a_sel=1 and alu_b_sel=00, and uses code 11. Word 7 gives rf_wr with rf_dst_rd=1 and wb_from_mem=0. Word 4 gives rf_wr with rf_dst_rd=0 and wb_from_mem=1. Words 4 and 7 use code 00.
- R11: Word 8 gives pc_wr_cond, pc_src=01, alu_fn=01, alu_a_sel=1 and alu_b_sel=00. Word 9 gives pc_wr with pc_src=10. Both words use code 00.
- R12: A change of opcode while the current word is not a dispatch word has no effect on the next microaddress.
- R13: mem_rd and mem_wr are never both high, and pc_wr and pc_wr_cond are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W | Opcode field of the held instruction |
| upc | output | UPC_W | Current microaddress |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load when the ALU reports zero |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register-file write |
| rf_dst_rd | output | 1 | Write destination: 1 rd field, 0 rt field |
| wb_from_mem | output | 1 | Write data: 1 memory data register, 0 ALU output register |
| alu_fn | output | 2 | 00 add, 01 subtract, 10 function-code driven |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 sign-extended, 11 sign-extended shifted by two |

## Verification
Two things can coincide in one cycle: a dispatch decision and a change of opcode. The bench provokes this in two ways. In one case it switches the opcode from load to store while word 2 is current, and expects word 5 next, because the table lookup uses the opcode of that cycle. In the other case it switches to a register opcode in word 2, and expects a return to fetch. Opcode changes made during non-dispatch words, such as word 0 or word 3, are judged by checking that the microaddress sequence stays exactly as the plain in-order path predicts.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SQ_FETCH = 2'b00,
      SQ_DISP1 = 2'b01,
      SQ_DISP2 = 2'b10,
      SQ_NEXT  = 2'b11
   } seq_e;

   typedef enum logic [1:0] {
      MEM_IDLE   = 2'd0,
      MEM_RD_PC  = 2'd1,
      MEM_RD_ALU = 2'd2,
      MEM_WR_ALU = 2'd3
   } mem_e;

   typedef enum logic [1:0] {
      RF_IDLE   = 2'd0,
      RF_WR_ALU = 2'd1,
      RF_WR_MDR = 2'd2
   } rf_e;

   typedef enum logic [1:0] {
      PCW_NONE = 2'd0,
      PCW_ALU  = 2'd1,
      PCW_COND = 2'd2,
      PCW_JUMP = 2'd3
   } pcw_e;

   typedef struct packed {
      logic [1:0] alu_fn;
      logic       a_sel;
      logic [1:0] b_sel;
      mem_e       mem;
      rf_e        rf;
      pcw_e       pcw;
      seq_e       seq;
   } uword_t;

   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_MEM1   = 2;
   localparam int UA_LDRD   = 3;
   localparam int UA_LDWB   = 4;
   localparam int UA_ST     = 5;
   localparam int UA_ROP    = 6;
   localparam int UA_RWB    = 7;
   localparam int UA_BR     = 8;
   localparam int UA_JMP    = 9;
   localparam int UA_WORDS  = 10;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic [UPC_W-1:0] addr,
   output uword_t           word
);

   always_comb begin
      word = '0;
      case (int'(addr))
         UA_FETCH: begin
            word.b_sel = 2'b01;
            word.mem   = MEM_RD_PC;
            word.pcw   = PCW_ALU;
            word.seq   = SQ_NEXT;
         end
         UA_DECODE: begin
            word.b_sel = 2'b11;
            word.seq   = SQ_DISP1;
         end
         UA_MEM1: begin
            word.a_sel = 1'b1;
            word.b_sel = 2'b10;
            word.seq   = SQ_DISP2;
         end
         UA_LDRD: begin
            word.mem = MEM_RD_ALU;
            word.seq = SQ_NEXT;
         end
         UA_LDWB: word.rf  = RF_WR_MDR;
         UA_ST:   word.mem = MEM_WR_ALU;
         UA_ROP: begin
            word.alu_fn = 2'b10;
            word.a_sel  = 1'b1;
            word.seq    = SQ_NEXT;
         end
         UA_RWB: word.rf = RF_WR_ALU;
         UA_BR: begin
            word.alu_fn = 2'b01;
            word.a_sel  = 1'b1;
            word.pcw    = PCW_COND;
         end
         UA_JMP: word.pcw = PCW_JUMP;
         default: word = '0;
      endcase
   end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
   parameter int          UPC_W    = 4,
   parameter int          OP_W     = 6,
   parameter int          TABLE_ID = 1,
   parameter logic [5:0]  OP_RTYPE = 6'h00,
   parameter logic [5:0]  OP_LOAD  = 6'h23,
   parameter logic [5:0]  OP_STORE = 6'h2B,
   parameter logic [5:0]  OP_BEQ   = 6'h04,
   parameter logic [5:0]  OP_JUMP  = 6'h02
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] target
);
   import useq_pkg::*;

   localparam logic [OP_W-1:0] K_R  = OP_W'(OP_RTYPE);
   localparam logic [OP_W-1:0] K_LD = OP_W'(OP_LOAD);
   localparam logic [OP_W-1:0] K_ST = OP_W'(OP_STORE);
   localparam logic [OP_W-1:0] K_BR = OP_W'(OP_BEQ);
   localparam logic [OP_W-1:0] K_J  = OP_W'(OP_JUMP);

   generate
      if (TABLE_ID == 1) begin : g_tbl1
         always_comb begin
            if (opcode == K_R)                         target = UPC_W'(UA_ROP);
            else if (opcode == K_J)                    target = UPC_W'(UA_JMP);
            else if (opcode == K_BR)                   target = UPC_W'(UA_BR);
            else if (opcode == K_LD || opcode == K_ST) target = UPC_W'(UA_MEM1);
            else                                       target = UPC_W'(UA_FETCH);
         end
      end else if (TABLE_ID == 2) begin : g_tbl2
         always_comb begin
            if (opcode == K_LD)      target = UPC_W'(UA_LDRD);
            else if (opcode == K_ST) target = UPC_W'(UA_ST);
            else                     target = UPC_W'(UA_FETCH);
         end
      end else begin : g_bad_tbl
         $error("useq_dispatch: TABLE_ID must be 1 or 2");
         assign target = '0;
      end
   endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  seq_e             seq,
   input  logic [UPC_W-1:0] upc,
   input  logic [UPC_W-1:0] disp1,
   input  logic [UPC_W-1:0] disp2,
   output logic [UPC_W-1:0] upc_nxt
);

   always_comb begin
      case (seq)
         SQ_NEXT:  upc_nxt = upc + UPC_W'(1);
         SQ_DISP1: upc_nxt = disp1;
         SQ_DISP2: upc_nxt = disp2;
         default:  upc_nxt = UPC_W'(UA_FETCH);
      endcase
   end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
(
   input  uword_t     word,
   output logic       pc_wr,
   output logic       pc_wr_cond,
   output logic [1:0] pc_src,
   output logic       addr_sel,
   output logic       mem_rd,
   output logic       mem_wr,
   output logic       ir_ld,
   output logic       rf_wr,
   output logic       rf_dst_rd,
   output logic       wb_from_mem,
   output logic [1:0] alu_fn,
   output logic       alu_a_sel,
   output logic [1:0] alu_b_sel
);

   assign alu_fn    = word.alu_fn;
   assign alu_a_sel = word.a_sel;
   assign alu_b_sel = word.b_sel;

   always_comb begin
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      ir_ld    = 1'b0;
      addr_sel = 1'b0;
      case (word.mem)
         MEM_RD_PC: begin
            mem_rd = 1'b1;
            ir_ld  = 1'b1;
         end
         MEM_RD_ALU: begin
            mem_rd   = 1'b1;
            addr_sel = 1'b1;
         end
         MEM_WR_ALU: begin
            mem_wr   = 1'b1;
            addr_sel = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      rf_wr       = 1'b0;
      rf_dst_rd   = 1'b0;
      wb_from_mem = 1'b0;
      case (word.rf)
         RF_WR_ALU: begin
            rf_wr     = 1'b1;
            rf_dst_rd = 1'b1;
         end
         RF_WR_MDR: begin
            rf_wr       = 1'b1;
            wb_from_mem = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      pc_wr      = 1'b0;
      pc_wr_cond = 1'b0;
      pc_src     = 2'b00;
      case (word.pcw)
         PCW_ALU:  pc_wr = 1'b1;
         PCW_COND: begin
            pc_wr_cond = 1'b1;
            pc_src     = 2'b01;
         end
         PCW_JUMP: begin
            pc_wr  = 1'b1;
            pc_src = 2'b10;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
   parameter int         UPC_W    = 4,
   parameter int         OP_W     = 6,
   parameter logic [5:0] OP_RTYPE = 6'h00,
   parameter logic [5:0] OP_LOAD  = 6'h23,
   parameter logic [5:0] OP_STORE = 6'h2B,
   parameter logic [5:0] OP_BEQ   = 6'h04,
   parameter logic [5:0] OP_JUMP  = 6'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] upc,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic [1:0]       pc_src,
   output logic             addr_sel,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             ir_ld,
   output logic             rf_wr,
   output logic             rf_dst_rd,
   output logic             wb_from_mem,
   output logic [1:0]       alu_fn,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel
);
   import useq_pkg::*;

   localparam int UPC_MIN = $clog2(UA_WORDS);

   generate
      if (UPC_W < UPC_MIN) begin : g_bad_upc
         $error("useq_ctrl: UPC_W too narrow for the microprogram");
      end
      if (OP_W != 6) begin : g_bad_op
         $error("useq_ctrl: OP_W must be 6");
      end
   endgenerate

   uword_t           cur_word;
   seq_e             seq_sel;
   logic [UPC_W-1:0] disp1_tgt;
   logic [UPC_W-1:0] disp2_tgt;
   logic [UPC_W-1:0] upc_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= UPC_W'(UA_FETCH);
      else        upc <= upc_nxt;
   end

   useq_rom #(.UPC_W(UPC_W)) u_rom (.addr(upc), .word(cur_word));

   assign seq_sel = cur_word.seq;

   useq_dispatch #(
      .UPC_W(UPC_W), .OP_W(OP_W), .TABLE_ID(1),
      .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
      .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
   ) u_disp1 (.opcode(opcode), .target(disp1_tgt));

   useq_dispatch #(
      .UPC_W(UPC_W), .OP_W(OP_W), .TABLE_ID(2),
      .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
      .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
   ) u_disp2 (.opcode(opcode), .target(disp2_tgt));

   useq_next #(.UPC_W(UPC_W)) u_next (
      .seq(seq_sel), .upc(upc), .disp1(disp1_tgt), .disp2(disp2_tgt),
      .upc_nxt(upc_nxt)
   );

   useq_decode u_dec (
      .word(cur_word), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .pc_src(pc_src), .addr_sel(addr_sel), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .ir_ld(ir_ld), .rf_wr(rf_wr),
      .rf_dst_rd(rf_dst_rd), .wb_from_mem(wb_from_mem),
      .alu_fn(alu_fn), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel)
   );

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
   import useq_pkg::*;
#(
   parameter int         UPC_W   = 4,
   parameter int         OP_W    = 6,
   parameter logic [5:0] OP_LOAD = 6'h23,
   parameter logic [5:0] OP_JUMP = 6'h02
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OP_W-1:0]  opcode,
   input logic [UPC_W-1:0] upc,
   input seq_e             seq_sel,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             pc_wr,
   input logic             pc_wr_cond
);

   // R1
   reset_fetch_chk: assert property (@(posedge clk) !rst_n |-> (upc == '0));

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_sel == SQ_NEXT) |=> (upc == $past(upc) + UPC_W'(1)));

   // R3
   back_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_sel == SQ_FETCH) |=> (upc == '0));

   // R4
   jump_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_sel == SQ_DISP1 && opcode == OP_W'(OP_JUMP)) |=> (upc == UPC_W'(UA_JMP)));

   // R5
   load_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_sel == SQ_DISP2 && opcode == OP_W'(OP_LOAD)) |=> (upc == UPC_W'(UA_LDRD)));

   // R13
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R13
   pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pc_wr && pc_wr_cond));

endmodule

bind useq_ctrl useq_ctrl_chk #(
   .UPC_W(UPC_W), .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_JUMP(OP_JUMP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
   .seq_sel(seq_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond)
);

// File: tb/tb_useq_ctrl.sv
`timescale 1ns/1ps
module tb_useq_ctrl;

   localparam logic [5:0] OR = 6'h00, OL = 6'h23, OS = 6'h2B,
                          OB = 6'h04, OJ = 6'h02, OX = 6'h3F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;
   logic [3:0] upc;
   logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld;
   logic       rf_wr, rf_dst_rd, wb_from_mem, alu_a_sel;
   logic [1:0] pc_src, alu_fn, alu_b_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   useq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
      .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .ir_ld(ir_ld), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
      .wb_from_mem(wb_from_mem), .alu_fn(alu_fn),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel)
   );

   // {opcode, expected microaddress}; walks every class after reset (R4, R5, R6)
   localparam int NV = 22;
   localparam logic [9:0] VEC [NV] = '{
      {OL,4'd0}, {OL,4'd1}, {OL,4'd2}, {OL,4'd3}, {OL,4'd4},
      {OS,4'd0}, {OS,4'd1}, {OS,4'd2}, {OS,4'd5},
      {OR,4'd0}, {OR,4'd1}, {OR,4'd6}, {OR,4'd7},
      {OB,4'd0}, {OB,4'd1}, {OB,4'd8},
      {OJ,4'd0}, {OJ,4'd1}, {OJ,4'd9},
      {OX,4'd0}, {OX,4'd1}, {OL,4'd0}
   };

   // {pc_wr,pc_wr_cond,pc_src,addr_sel,mem_rd,mem_wr,ir_ld,
   //  rf_wr,rf_dst_rd,wb_from_mem,alu_fn,alu_a_sel,alu_b_sel}
   function automatic logic [15:0] exp_ctl(input int s);
      case (s)
         0: return 16'h8501; // R7
         1: return 16'h0003; // R8
         2: return 16'h0006; // R9
         3: return 16'h0C00; // R9
         4: return 16'h00A0; // R10
         5: return 16'h0A00; // R9
         6: return 16'h0014; // R10
         7: return 16'h00C0; // R10
         8: return 16'h500C; // R11
         9: return 16'hA000; // R11
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string ctl_tag(input int s);
      case (s)
         0: return "R7";
         1: return "R8";
         2, 3, 5: return "R9";
         4, 6, 7: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [15:0] act_ctl();
      return {pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_ld,
              rf_wr, rf_dst_rd, wb_from_mem, alu_fn, alu_a_sel, alu_b_sel};
   endfunction

   task automatic check_now(input int exp_upc, input string tag);
      total++;
      if (upc !== 4'(exp_upc)) begin
         bad++;
         $display("FAIL %s upc actual=%0d expected=%0d", tag, upc, exp_upc);
      end
      total++;
      if (act_ctl() !== exp_ctl(exp_upc)) begin
         bad++;
         $display("FAIL %s ctl@%0d actual=%h expected=%h", ctl_tag(exp_upc),
                  exp_upc, act_ctl(), exp_ctl(exp_upc));
      end
      total++;
      if ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond)) begin
         bad++;
         $display("FAIL R13 exclusive strobes actual=%b%b%b%b expected=no pair",
                  mem_rd, mem_wr, pc_wr, pc_wr_cond);
      end
   endtask

   task automatic step(input logic [5:0] op, input int exp_upc, input string tag);
      opcode = op;
      #1;
      check_now(exp_upc, tag);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #1;
      check_now(0, "R1");
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // table walk: sequencing R2, R3, dispatch R4, R5, R6
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9:4], int'(VEC[i][3:0]), "R2/R3/R4/R5/R6 path");
      end

      // R12: opcode changes outside dispatch words do nothing
      do_reset();
      step(OJ, 0, "R12");
      step(OL, 1, "R12");
      step(OL, 2, "R12");
      step(OB, 3, "R12");
      step(OR, 4, "R12");
      step(OR, 0, "R12");

      // R5: opcode switched in the second-dispatch cycle
      do_reset();
      step(OL, 0, "R5");
      step(OL, 1, "R5");
      step(OS, 2, "R5");
      step(OS, 5, "R5");
      step(OS, 0, "R3");

      // R6: register opcode at second dispatch returns to fetch
      do_reset();
      step(OL, 0, "R6");
      step(OL, 1, "R6");
      step(OR, 2, "R6");
      step(OR, 0, "R6");

      // R1: reset in the middle of a load
      step(OL, 1, "R4");
      step(OL, 2, "R4");
      step(OL, 3, "R5");
      do_reset();
      step(OL, 0, "R1");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule